// File: doc/BRIEF.md
# SPI Control-Register and Buffer Command Decoder

This block is an SPI slave that gives a host access to a banked file of 8-bit control registers and to a packet-buffer memory port. Each transaction starts with chip select going low. The first byte is an instruction: a 3-bit opcode in bits 7:5 and a 5-bit argument in bits 4:0. The data bytes that follow are written, read, or merged into the selected register, or streamed to or from the buffer memory through an auto-incrementing pointer.

The register file holds 128 bytes: four banks of 32 locations. The argument selects a location within the bank named by bits 1:0 of the common register at argument 1Fh. Arguments 1Bh to 1Fh always reach the same five shared registers, whatever the bank. A per-location class table marks the slower register group. Reads from that group insert a zero dummy byte before the data.

SPI pins are sampled in the system clock domain through two-stage synchronisers. Every register update is reported on a write-notification port. The buffer memory sits outside the block and answers reads combinationally.

Top module: `spi_cmd_decoder`

## Requirements
- R1: SPI mode 0 only. MOSI is sampled on the rising edge of SCK, MSB first. MISO changes only after a falling edge of SCK, and it is low out of reset.
- R2: Raising chip select ends the instruction. A partial command or data byte has no effect, and the next low chip select starts a new instruction.
- R3: Opcode 010 (write register) stores every following data byte into the addressed register. Each store gives one reg_we pulse carrying the register index and the value.
- R4: Opcode 100 (bit set) replaces the register with its value OR the data byte.
- R5: Opcode 101 (bit clear) replaces the register with its value AND the complement of the data byte.
- R6: For arguments 00h to 1Ah, the register index is bank*32 + argument. The bank is bits 1:0 of the shared register at 1Fh.
- R7: Arguments 1Bh to 1Fh map to indices 1Bh to 1Fh in every bank.
- R8: Opcode 000 (read register) on a slow-class index returns a 0x00 dummy byte, then the register value. By default the slow class is bank 2 indices 40h to 5Ah, bank 3 indices 60h to 65h, and index 6Ah.
- R9: Opcode 000 on any other index returns the register value in the byte right after the instruction.
- R10: Instruction 0x7A writes each data byte to the buffer at the pointer, pulsing buf_wr once per byte, and then advances the pointer by one.
- R11: Instruction 0x3A returns buffer bytes starting at the pointer, and the pointer advances by one for each byte fully shifted out.
- R12: Instruction 0xFF, once chip select rises, clears all registers (and so the bank select) and the buffer pointer to zero.
- R13: Any other instruction byte causes no register or buffer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck | input | 1 | SPI clock, idles low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| reg_we | output | 1 | Pulse: a register was updated |
| reg_idx | output | 7 | Index (bank*32+argument) of the updated register |
| reg_wdata | output | 8 | New value of the updated register |
| buf_addr | output | PTR_W | Buffer pointer |
| buf_wr | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| buf_rd | output | 1 | Buffer read strobe (byte taken from buf_rdata) |
| buf_rdata | input | 8 | Buffer read data for buf_addr, combinational |

## Verification
The assertions assume that SCK is slow against the system clock, with each level held for at least three clock cycles. They also assume MOSI is settled before the rising SCK edge and chip select moves only while SCK is low. Under those conditions each SCK edge becomes exactly one detected edge, and the bank and pointer relations hold.

The bench keeps to these limits. It drives every pin on the falling clock edge and holds each SCK level for six cycles. It changes chip select only at byte boundaries, or mid-byte while SCK is low.

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder #(
  parameter int PTR_W = 13,
  parameter logic [127:0] SLOW_MAP = (((128'd1 << 27) - 128'd1) << 64)
                                   | (((128'd1 << 6) - 128'd1) << 96)
                                   | (128'd1 << 106)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             mosi,
  output logic             miso,
  output logic             reg_we,
  output logic [6:0]       reg_idx,
  output logic [7:0]       reg_wdata,
  output logic [PTR_W-1:0] buf_addr,
  output logic             buf_wr,
  output logic [7:0]       buf_wdata,
  output logic             buf_rd,
  input  logic [7:0]       buf_rdata
);
  logic [2:0] sck_q, cs_q;
  logic [1:0] mosi_q;
  logic [2:0] bitcnt;
  logic [1:0] nbyte;
  logic [7:0] cmd, sin, sout;
  logic [PTR_W-1:0] ptr;
  logic rd_adv;
  logic [7:0] regs [128];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= '0; cs_q <= '1; mosi_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      cs_q <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  wire rise   = sck_q[1] & ~sck_q[2];
  wire fall   = ~sck_q[1] & sck_q[2];
  wire cs_act = ~cs_q[1];
  wire cs_up  = cs_q[1] & ~cs_q[2];

  wire [2:0] op    = cmd[7:5];
  wire [4:0] arg   = cmd[4:0];
  wire is_rcr  = op == 3'b000;
  wire is_wcr  = op == 3'b010;
  wire is_bfs  = op == 3'b100;
  wire is_bfc  = op == 3'b101;
  wire is_rbm  = cmd == 8'h3A;
  wire is_wbm  = cmd == 8'h7A;
  wire is_srst = cmd == 8'hFF;

  wire [1:0] bank = regs[31][1:0];
  wire [6:0] idx  = (arg >= 5'h1B) ? {2'b00, arg} : {bank, arg};
  wire       slow = SLOW_MAP[idx];
  wire [7:0] rx   = {sin[6:0], mosi_q[1]};

  logic [7:0] wval, load_val;
  always_comb begin
    wval = rx;
    if (is_bfs) wval = regs[idx] | rx;
    else if (is_bfc) wval = regs[idx] & ~rx;
    load_val = 8'h00;
    if (is_rcr) load_val = (slow && nbyte == 2'd1) ? 8'h00 : regs[idx];
    else if (is_rbm) load_val = buf_rdata;
  end

  always_ff @(posedge clk) begin
    reg_we <= 1'b0;
    buf_wr <= 1'b0;
    buf_rd <= 1'b0;
    rd_adv <= 1'b0;
    if (buf_wr || rd_adv) ptr <= ptr + 1'b1;
    if (rst) begin
      bitcnt <= '0; nbyte <= '0; cmd <= '0; sin <= '0; sout <= '0; ptr <= '0;
      reg_idx <= '0; reg_wdata <= '0; buf_wdata <= '0;
      for (int i = 0; i < 128; i++) regs[i] <= 8'h00;
    end else if (!cs_act) begin
      bitcnt <= '0;
      nbyte <= '0;
      if (cs_up && nbyte != 2'd0 && is_srst) begin
        ptr <= '0;
        for (int i = 0; i < 128; i++) regs[i] <= 8'h00;
      end
    end else begin
      if (rise) begin
        sin <= rx;
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          if (nbyte != 2'd2) nbyte <= nbyte + 2'd1;
          if (nbyte == 2'd0) cmd <= rx;
          else begin
            if (is_wcr || is_bfs || is_bfc) begin
              regs[idx] <= wval;
              reg_we <= 1'b1;
              reg_idx <= idx;
              reg_wdata <= wval;
            end
            if (is_wbm) begin
              buf_wr <= 1'b1;
              buf_wdata <= rx;
            end
            if (is_rbm) rd_adv <= 1'b1;
          end
        end
      end
      if (fall) begin
        if (bitcnt == 3'd0 && nbyte != 2'd0) begin
          sout <= load_val;
          if (is_rbm) buf_rd <= 1'b1;
        end else begin
          sout <= {sout[6:0], 1'b0};
        end
      end
    end
  end

  assign miso = sout[7];
  assign buf_addr = ptr;

  a_r1_miso_on_fall: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(miso));
  a_r2_cs_restart: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (bitcnt == 3'd0 && nbyte == 2'd0));
  a_r6_bank_index: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_idx[4:0] < 5'h1B) |-> reg_idx[6:5] == $past(bank));
  a_r7_common_window: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_idx[4:0] >= 5'h1B) |-> reg_idx[6:5] == 2'b00);
  a_r10_ptr_step: assert property (@(posedge clk) disable iff (rst)
    buf_wr |=> buf_addr == $past(buf_addr) + 1'b1);
  a_r13_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_we, buf_wr, buf_rd}));
endmodule

// File: tb/spi_cmd_decoder_bench.sv
module spi_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, reg_we, buf_wr, buf_rd;
  logic [6:0] reg_idx;
  logic [7:0] reg_wdata, buf_wdata, buf_rdata;
  logic [12:0] buf_addr;

  spi_cmd_decoder u_spi_cmd_decoder (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .buf_addr(buf_addr), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .buf_rd(buf_rd), .buf_rdata(buf_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] bmem [8192];
  assign buf_rdata = bmem[buf_addr];
  always @(posedge clk) if (buf_wr) bmem[buf_addr] <= buf_wdata;

  typedef struct { bit is_buf; logic [12:0] addr; logic [7:0] data; string tag; } ev_t;
  ev_t q[$];
  int checks = 0, errs = 0;
  logic [7:0] mreg [128];
  logic [1:0] mbank = 2'b00;
  logic [12:0] mptr = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && (reg_we || buf_wr)) begin
      if (q.size() == 0) begin
        checks++; errs++;
        $display("FAIL R13 unexpected write actual=%0h expected=none", reg_we ? reg_idx : buf_addr);
      end else begin
        ev_t e;
        e = q.pop_front();
        chk({e.tag, " kind"}, buf_wr, e.is_buf);
        chk({e.tag, " addr"}, reg_we ? 13'(reg_idx) : buf_addr, e.addr);
        chk({e.tag, " data"}, reg_we ? reg_wdata : buf_wdata, e.data);
      end
    end
  end

  function automatic logic [6:0] midx(input logic [4:0] a);
    return (a >= 5'h1B) ? {2'b00, a} : {mbank, a};
  endfunction

  function automatic bit mslow(input logic [6:0] i);
    return (i >= 7'h40 && i <= 7'h5A) || (i >= 7'h60 && i <= 7'h65) || i == 7'h6A;
  endfunction

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic reg_op(input logic [2:0] op, input logic [4:0] a, input logic [7:0] d, input string tag);
    logic [6:0] i;
    logic [7:0] v, rx;
    i = midx(a);
    v = (op == 3'b100) ? (mreg[i] | d) : (op == 3'b101) ? (mreg[i] & ~d) : d;
    mreg[i] = v;
    if (i == 7'h1F) mbank = v[1:0];
    q.push_back('{1'b0, 13'(i), v, tag});
    cs_lo();
    xfer({op, a}, 8, rx);
    xfer(d, 8, rx);
    cs_hi();
  endtask

  task automatic rd_reg(input logic [4:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] rx;
    cs_lo();
    xfer({3'b000, a}, 8, rx);
    if (mslow(midx(a))) begin
      xfer(8'h00, 8, rx);
      chk("R8 dummy byte", rx, 8'h00);
    end
    xfer(8'h00, 8, rx);
    chk(tag, rx, exp);
    cs_hi();
  endtask

  task automatic wr_buf(input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic [7:0] rx;
    logic [7:0] d [3];
    d = '{d0, d1, d2};
    cs_lo();
    xfer(8'h7A, 8, rx);
    for (int k = 0; k < 3; k++) begin
      q.push_back('{1'b1, mptr, d[k], "R10"});
      mptr++;
      xfer(d[k], 8, rx);
    end
    cs_hi();
  endtask

  task automatic rd_buf(input int n, input string tag);
    logic [7:0] rx;
    cs_lo();
    xfer(8'h3A, 8, rx);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, rx);
      chk(tag, rx, bmem[mptr]);
      mptr++;
    end
    cs_hi();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < 8192; i++) bmem[i] = 8'(i) ^ 8'h5C;
    for (int i = 0; i < 128; i++) mreg[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset miso", miso, 1'b0);
    chk("R10 reset pointer", buf_addr, 13'h0);
    chk("R3 reset reg_we", reg_we, 1'b0);

    reg_op(3'b010, 5'h05, 8'hA5, "R3");
    rd_reg(5'h05, 8'hA5, "R9 fast read");
    reg_op(3'b100, 5'h05, 8'h5A, "R4");
    rd_reg(5'h05, 8'hFF, "R4 readback");
    reg_op(3'b101, 5'h05, 8'h0F, "R5");
    rd_reg(5'h05, 8'hF0, "R5 readback");

    q.push_back('{1'b0, 13'h06, 8'h11, "R3 multi"});
    q.push_back('{1'b0, 13'h06, 8'h22, "R3 multi"});
    mreg[6] = 8'h22;
    cs_lo(); xfer(8'h46, 8, rx); xfer(8'h11, 8, rx); xfer(8'h22, 8, rx); cs_hi();
    rd_reg(5'h06, 8'h22, "R3 multi readback");

    reg_op(3'b010, 5'h1F, 8'h02, "R6 bank select");
    reg_op(3'b010, 5'h05, 8'h3C, "R6 bank2 write");
    rd_reg(5'h05, 8'h3C, "R8 slow read");
    reg_op(3'b010, 5'h1B, 8'h33, "R7");
    reg_op(3'b010, 5'h1F, 8'h01, "R6 bank select");
    rd_reg(5'h1B, 8'h33, "R7 common in bank1");
    rd_reg(5'h05, 8'h00, "R6 bank1 distinct");
    reg_op(3'b101, 5'h1F, 8'h03, "R6 bank clear");
    rd_reg(5'h05, 8'hF0, "R6 bank0 kept");

    wr_buf(8'hC1, 8'hC2, 8'hC3);
    rd_buf(2, "R11 stream");

    cs_lo(); xfer(8'hFF, 8, rx); cs_hi();
    for (int i = 0; i < 128; i++) mreg[i] = 8'h00;
    mbank = 2'b00; mptr = '0;
    chk("R12 pointer cleared", buf_addr, 13'h0);
    rd_reg(5'h05, 8'h00, "R12 reg cleared");
    rd_reg(5'h1F, 8'h00, "R12 bank cleared");
    rd_buf(3, "R11 after R12");

    cs_lo(); xfer(8'h46, 4, rx); cs_hi();
    cs_lo(); xfer(8'h47, 8, rx); xfer(8'h99, 5, rx); cs_hi();
    rd_reg(5'h07, 8'h00, "R2 partial ignored");
    reg_op(3'b010, 5'h07, 8'h77, "R2 restart");
    rd_reg(5'h07, 8'h77, "R2 readback");

    cs_lo(); xfer(8'h25, 8, rx); xfer(8'hAA, 8, rx); cs_hi();
    cs_lo(); xfer(8'hE5, 8, rx); xfer(8'hAA, 8, rx); cs_hi();
    rd_reg(5'h05, 8'h00, "R13 unknown ignored");
    chk("R13 pointer unmoved", buf_addr, mptr);
    chk("R3 queue drained", q.size(), 0);
    finish_run();
  end
endmodule